// File: doc/BRIEF.md
# PHY Power Sequencer

This block drives the control pins of a high-speed serial PHY through its power-up and power-down sequences. A single-cycle start request puts the PHY into reset for a programmable hold time. The block then releases reset and picks the reference source from an input that says whether an external crystal is fitted. It waits a programmable settle time, then raises PHY enable and lane-0 power-present together.

A single-cycle stop request takes the PHY down in three ordered steps, one clock apart. First PHY enable and lane-0 power-present drop. Then the reference-pad select drops. Last, the test power-down (retention) control is raised. `busy_o` is high while a sequence runs, and `done_o` pulses once when a sequence ends. Both wait times are given in microseconds and converted to clock cycles from `CLK_HZ`, so a bench can use short waits.

Top module: `phy_pwr_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, every output is 0: reset, pad select, enable, lane power, test power-down, busy and done.
- R2: A start request accepted at a clock edge sets `phy_reset_o` to 1 at that edge. It stays at 1 for exactly RST_CYC cycles, where RST_CYC = (CLK_HZ/1e6)*RST_US, with a minimum of 1.
- R3: At the edge where reset is released, `ref_pad_sel_o` takes the value of `xtal_present_i` sampled at that edge: 1 if a crystal is present, 0 if not.
- R4: `phy_en_o` and `lane_pwr_o` rise together exactly SETTLE_CYC cycles after reset is released, where SETTLE_CYC = (CLK_HZ/1e6)*SETTLE_US. Both are cleared at the edge where a start request is accepted.
- R5: A stop request clears `phy_en_o` and `lane_pwr_o` at the accepting edge. It clears `ref_pad_sel_o` one edge later and sets `test_pdn_o` one edge after that. `test_pdn_o` is cleared when a start request is accepted.
- R6: `busy_o` is high from the accepting edge until the final step of the sequence. `done_o` is a one-cycle pulse that appears in the same cycle as the final output change.
- R7: Requests that arrive while `busy_o` is high have no effect. If both requests arrive together while idle, the start request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_up_req_i | input | 1 | Start (power-up) request, one cycle |
| pwr_dn_req_i | input | 1 | Stop (power-down) request, one cycle |
| xtal_present_i | input | 1 | An external crystal reference is fitted |
| phy_reset_o | output | 1 | PHY reset |
| ref_pad_sel_o | output | 1 | Selects the pad reference input |
| phy_en_o | output | 1 | PHY enable |
| lane_pwr_o | output | 1 | Lane-0 power present |
| test_pdn_o | output | 1 | Test power-down / retention control |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Sequence-complete pulse |

## Verification
The start sequence is run with the crystal flag at 1 and at 0, which shows that the pad choice follows the flag sampled at reset release. It is also run from an already-enabled state, which shows that enable is cleared on entry. The stop sequence is run after a start, and again twice in a row, which exposes any reordering of the three steps. Requests are sent in the middle of a sequence, and both requests are sent together while idle, to separate "ignored while busy" from the start-over-stop priority. An asynchronous reset in the middle of the settle wait shows that the block returns to its idle outputs.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RST_HOLD,
    SEQ_SETTLE,
    SEQ_DN_PAD,
    SEQ_DN_PDN
  } seq_state_e;
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  timer_hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import phy_pwr_seq_pkg::*;
#(
  parameter int          W        = 8,
  parameter logic [W-1:0] RST_LOAD = '0,
  parameter logic [W-1:0] SET_LOAD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_req_i,
  input  logic         dn_req_i,
  input  logic         xtal_i,
  input  logic         tmr_zero_i,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o,
  output logic         phy_reset_o,
  output logic         ref_pad_sel_o,
  output logic         phy_en_o,
  output logic         lane_pwr_o,
  output logic         test_pdn_o,
  output logic         busy_o,
  output logic         done_o
);
  seq_state_e state_q;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = RST_LOAD;
    if (state_q == SEQ_IDLE && up_req_i) begin
      tmr_load_o = 1'b1;
    end else if (state_q == SEQ_RST_HOLD && tmr_zero_i) begin
      tmr_load_o = 1'b1;
      tmr_val_o  = SET_LOAD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= SEQ_IDLE;
      phy_reset_o   <= 1'b0;
      ref_pad_sel_o <= 1'b0;
      phy_en_o      <= 1'b0;
      lane_pwr_o    <= 1'b0;
      test_pdn_o    <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (up_req_i) begin
            phy_reset_o <= 1'b1;
            phy_en_o    <= 1'b0;
            lane_pwr_o  <= 1'b0;
            test_pdn_o  <= 1'b0;
            state_q     <= SEQ_RST_HOLD;
          end else if (dn_req_i) begin
            phy_en_o   <= 1'b0;
            lane_pwr_o <= 1'b0;
            state_q    <= SEQ_DN_PAD;
          end
        end
        SEQ_RST_HOLD: if (tmr_zero_i) begin
          phy_reset_o   <= 1'b0;
          ref_pad_sel_o <= xtal_i;
          state_q       <= SEQ_SETTLE;
        end
        SEQ_SETTLE: if (tmr_zero_i) begin
          phy_en_o   <= 1'b1;
          lane_pwr_o <= 1'b1;
          done_o     <= 1'b1;
          state_q    <= SEQ_IDLE;
        end
        SEQ_DN_PAD: begin
          ref_pad_sel_o <= 1'b0;
          state_q       <= SEQ_DN_PDN;
        end
        SEQ_DN_PDN: begin
          test_pdn_o <= 1'b1;
          done_o     <= 1'b1;
          state_q    <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SEQ_IDLE);

  // R2
  reset_excl_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_reset_o |-> !phy_en_o);
  // R4
  en_after_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_en_o) |-> (!phy_reset_o && lane_pwr_o && $past(state_q == SEQ_SETTLE)));
  // R5
  pad_after_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_pad_sel_o) |-> !phy_en_o);
  // R5
  pdn_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_pdn_o) |-> (!ref_pad_sel_o && !phy_en_o && !lane_pwr_o));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(phy_reset_o) && phy_reset_o) |-> 1'b0);
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int RST_US    = 2000,
  parameter int SETTLE_US = 30000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_up_req_i,
  input  logic pwr_dn_req_i,
  input  logic xtal_present_i,
  output logic phy_reset_o,
  output logic ref_pad_sel_o,
  output logic phy_en_o,
  output logic lane_pwr_o,
  output logic test_pdn_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int RST_CYC    = (CYC_PER_US * RST_US > 0) ? CYC_PER_US * RST_US : 1;
  localparam int SET_CYC    = (CYC_PER_US * SETTLE_US > 0) ? CYC_PER_US * SETTLE_US : 1;
  localparam int MAX_CYC    = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
  localparam int W          = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [W-1:0] RST_LOAD = W'(RST_CYC - 1);
  localparam logic [W-1:0] SET_LOAD = W'(SET_CYC - 1);

  logic         tmr_load;
  logic [W-1:0] tmr_val;
  logic         tmr_zero;

  pwrseq_timer #(.W(W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  pwrseq_fsm #(.W(W), .RST_LOAD(RST_LOAD), .SET_LOAD(SET_LOAD)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .up_req_i      (pwr_up_req_i),
    .dn_req_i      (pwr_dn_req_i),
    .xtal_i        (xtal_present_i),
    .tmr_zero_i    (tmr_zero),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .phy_reset_o   (phy_reset_o),
    .ref_pad_sel_o (ref_pad_sel_o),
    .phy_en_o      (phy_en_o),
    .lane_pwr_o    (lane_pwr_o),
    .test_pdn_o    (test_pdn_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );
endmodule

// File: tb/phy_pwr_seq_bench.sv
`timescale 1ns/1ps
module phy_pwr_seq_bench;
  localparam int RST_N = 5;
  localparam int SET_N = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, dn = 1'b0, xtal = 1'b0;
  logic o_rst, o_pad, o_en, o_lane, o_pdn, o_busy, o_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  phy_pwr_seq #(.CLK_HZ(1_000_000), .RST_US(RST_N), .SETTLE_US(SET_N)) u_phy_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_req_i(up), .pwr_dn_req_i(dn),
    .xtal_present_i(xtal), .phy_reset_o(o_rst), .ref_pad_sel_o(o_pad),
    .phy_en_o(o_en), .lane_pwr_o(o_lane), .test_pdn_o(o_pdn),
    .busy_o(o_busy), .done_o(o_done)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int ph = 0, left = 0;
  bit m_rst, m_pad, m_en, m_lane, m_pdn, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; left = 0;
      m_rst = 0; m_pad = 0; m_en = 0; m_lane = 0; m_pdn = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (ph == 0) begin
        if (up) begin
          m_rst = 1; m_en = 0; m_lane = 0; m_pdn = 0; ph = 1; left = RST_N;
        end else if (dn) begin
          m_en = 0; m_lane = 0; ph = 3;
        end
      end else if (ph == 1) begin
        left--;
        if (left == 0) begin m_rst = 0; m_pad = xtal; ph = 2; left = SET_N; end
      end else if (ph == 2) begin
        left--;
        if (left == 0) begin m_en = 1; m_lane = 1; m_done = 1; ph = 0; end
      end else if (ph == 3) begin
        m_pad = 0; ph = 4;
      end else begin
        m_pdn = 1; m_done = 1; ph = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!finished) begin
      chk("R2 phy_reset", o_rst, m_rst);
      chk("R3 ref_pad_sel", o_pad, m_pad);
      chk("R4 phy_en", o_en, m_en);
      chk("R4 lane_pwr", o_lane, m_lane);
      chk("R5 test_pdn", o_pdn, m_pdn);
      chk("R6 busy", o_busy, ph != 0);
      chk("R6 done", o_done, m_done);
    end
  end

  task automatic req(input bit u, input bit d);
    @(negedge clk); up = u; dn = d;
    @(negedge clk); up = 0; dn = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(2);
    #1;
    chk("R1 reset outputs", {o_rst, o_pad, o_en, o_lane, o_pdn, o_busy, o_done}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {o_rst, o_pad, o_en, o_lane, o_pdn, o_busy, o_done}, 0);

    // R2 R3 R4 crystal present
    xtal = 1;
    req(1, 0);
    begin
      int w = 1;
      while (o_rst) begin @(negedge clk); w++; end
      chk("R2 reset width", w - 1, RST_N);
    end
    idle(SET_N + 2);
    chk("R3 pad with xtal", o_pad, 1);
    chk("R4 enabled", {o_en, o_lane}, 3);

    // R5 ordered down
    req(0, 1);
    idle(4);
    chk("R5 down final", {o_en, o_pad, o_pdn}, 1);

    // R3 no crystal, R7 stop during busy ignored
    xtal = 0;
    req(1, 0);
    idle(3);
    req(0, 1);
    idle(RST_N + SET_N + 2);
    chk("R7 stop ignored while busy", o_en, 1);
    chk("R3 pad without xtal", o_pad, 0);

    // R4 restart from enabled, R7 start ignored mid-sequence
    xtal = 1;
    req(1, 0);
    chk("R4 en cleared on start", o_en, 0);
    idle(RST_N + 2);
    req(1, 0);
    idle(SET_N + 2);
    chk("R7 start ignored while busy", o_busy, 0);

    // R7 simultaneous: start wins
    req(0, 1); idle(4);
    req(1, 1);
    chk("R7 start wins", o_rst, 1);
    idle(RST_N + SET_N + 2);

    // R5 double stop
    req(0, 1); idle(4);
    req(0, 1); idle(4);
    chk("R5 double stop", o_pdn, 1);

    // R1 async reset mid-settle
    req(1, 0);
    idle(RST_N + 3);
    #1 rst_n = 0;
    #2;
    chk("R1 async reset", {o_rst, o_pad, o_en, o_lane, o_pdn, o_busy, o_done}, 0);
    @(negedge clk); rst_n = 1;
    idle(3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule